// File: doc/BRIEF.md
# Adaptive Per-Core Thread-Block Limit Controller

This block sits next to one SIMT core and decides how many thread blocks (CTAs) the core should keep in play. The core reports two status pulses every cycle. One says the pipeline is free but has no thread ready to issue. The other says every resident warp is stalled on a memory return. The block counts both pulses over a fixed sampling window. When the window closes, it sorts the idle total into two levels and the memory total into three levels. From those levels it moves a target CTA count up by one, down by one, or leaves it where it is. The target always stays between one and the core's hardware maximum N.

A CTA that is already running cannot be taken off the core. So when the target falls below the number of resident CTAs, the block does not evict anything. It reports a pause count instead: that many of the most recently assigned CTAs are to lose warp-scheduler priority. When the target rises again, paused CTAs are released before any new CTA is requested. A new-CTA request goes out only when nothing is paused and the resident count is below the target. The dispatcher reports each CTA it places on the core and each CTA that completes.

The window length and the three thresholds are taken from configuration inputs only while reset is held.

Top module: `tlp_limit_ctrl`

## Requirements
- R1: During and after reset, and before any window closes, the target equals floor(N/2). With the default N=8 that is 4. The pause count is 0, pause_req is low, and grant_req is high, because no CTA is resident.
- R2: A window lasts cfg_window cycles, starting with the first clock after reset is released. The decision counts the pulses from every cycle of the window, the last cycle included. The new target, pause count and grant state are visible in the cycle right after the window's last cycle.
- R3: If the idle total of a window is at least cfg_idle_thr, the target rises by one, whatever the memory total is.
- R4: If the idle total is below cfg_idle_thr and the memory total is below cfg_mem_lo, the target rises by one.
- R5: If the idle total is below cfg_idle_thr and the memory total lies in the range cfg_mem_lo ≤ total < cfg_mem_hi, the target is unchanged.
- R6: If the idle total is below cfg_idle_thr and the memory total is at least cfg_mem_hi, the target falls by one.
- R7: Both totals restart from zero at the start of every window, so pulses from one window never count in the next.
- R8: The target never rises above N and never falls below 1. A rise at N leaves the target at N, and a fall at 1 leaves it at 1.
- R9: The pause count moves by at most one per cycle, in the same cycle as a target update, toward max(0, resident − target). pause_req is high exactly when the pause count is non-zero. Releasing paused CTAs comes before requesting new ones.
- R10: The resident count goes up by one on each cta_launch cycle, unless it is already N, and down by one on each cta_retire cycle. grant_req is high exactly when the pause count is 0 and the resident count is below the target.
- R11: Changes on the configuration inputs after reset is released have no effect on any window length or decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while it is low |
| cfg_window | input | CNT_W | Sampling window length in cycles |
| cfg_idle_thr | input | CNT_W | Idle total at or above which the idle level is high |
| cfg_mem_lo | input | CNT_W | Memory total below which the memory level is low |
| cfg_mem_hi | input | CNT_W | Memory total at or above which the memory level is high |
| core_idle | input | 1 | Pipeline free but no thread ready this cycle |
| core_mem_wait | input | 1 | All resident warps waiting on memory this cycle |
| cta_launch | input | 1 | Dispatcher placed a CTA on the core this cycle |
| cta_retire | input | 1 | A CTA on the core completed this cycle |
| target_cta | output | CW | Current target CTA count |
| pause_cnt | output | CW | Number of most recently assigned CTAs to deprioritize |
| pause_req | output | 1 | At least one CTA is paused |
| grant_req | output | 1 | Request one more CTA from the dispatcher |

## Verification
Every window result is due in exactly one cycle. With reset released, window j closes on clock edge (j+1)·W, and target, pause count and grant are sampled on the falling edge that follows. The driver tags each expected item with that edge number. The monitor compares an item only when the bench's own edge counter reaches that number. Launch and retire pulses are placed at the start of a window, so the pause count has already settled by the time its single step at the window boundary is checked.

// File: rtl/tlp_pkg.sv
// Shared types for the thread-block limit controller.
// Assumes nothing beyond standard SystemVerilog enums.
package tlp_pkg;

    // Per-window adjustment of the target count
    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_e;

    // Memory-stall level of a window
    typedef enum logic [1:0] {
        MEM_LOW  = 2'd0,
        MEM_MID  = 2'd1,
        MEM_HIGH = 2'd2
    } mem_lvl_e;

endpackage

// File: rtl/tlp_cfg_latch.sv
// Holds the window length and thresholds.
// Captures the configuration inputs on every clock while reset is low,
// then keeps them for the rest of the run. Inputs are assumed to be
// stable during reset.
module tlp_cfg_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] in_window,
    input  logic [CNT_W-1:0] in_idle_thr,
    input  logic [CNT_W-1:0] in_mem_lo,
    input  logic [CNT_W-1:0] in_mem_hi,
    output logic [CNT_W-1:0] win_len,
    output logic [CNT_W-1:0] idle_thr,
    output logic [CNT_W-1:0] mem_lo,
    output logic [CNT_W-1:0] mem_hi
);

    // Capture while in reset, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_len  <= in_window;
            idle_thr <= in_idle_thr;
            mem_lo   <= in_mem_lo;
            mem_hi   <= in_mem_hi;
        end
    end

endmodule

// File: rtl/tlp_stall_sampler.sv
// Counts idle and memory-stall cycles over a fixed-length window.
// win_end marks the window's last cycle. The *_sum outputs include that
// cycle's pulse, so they hold the complete window totals when win_end is
// high. A window length below 1 is not supported.
module tlp_stall_sampler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] win_len,
    input  logic             core_idle,
    input  logic             core_mem_wait,
    output logic             win_end,
    output logic [CNT_W-1:0] idle_sum,
    output logic [CNT_W-1:0] mem_sum
);

    logic [CNT_W-1:0] win_cnt;
    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W-1:0] mem_cnt;

    // Window end and running totals including this cycle
    always_comb begin
        win_end  = (win_cnt == win_len - CNT_W'(1));
        idle_sum = idle_cnt + CNT_W'(core_idle);
        mem_sum  = mem_cnt + CNT_W'(core_mem_wait);
    end

    // Advance the window position and accumulate; clear at window end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            idle_cnt <= '0;
            mem_cnt  <= '0;
        end else if (win_end) begin
            win_cnt  <= '0;
            idle_cnt <= '0;
            mem_cnt  <= '0;
        end else begin
            win_cnt  <= win_cnt + CNT_W'(1);
            idle_cnt <= idle_sum;
            mem_cnt  <= mem_sum;
        end
    end

endmodule

// File: rtl/tlp_adjust_decider.sv
// Combinational decision table.
// A high idle level always raises the target. Otherwise the memory level
// decides: low raises, medium holds, high lowers.
// Assumes mem_lo <= mem_hi.
module tlp_adjust_decider
    import tlp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] idle_sum,
    input  logic [CNT_W-1:0] mem_sum,
    input  logic [CNT_W-1:0] idle_thr,
    input  logic [CNT_W-1:0] mem_lo,
    input  logic [CNT_W-1:0] mem_hi,
    output adj_e             adj
);

    logic     idle_high;
    mem_lvl_e mem_lvl;

    // Classify the two totals into levels
    always_comb begin
        idle_high = (idle_sum >= idle_thr);
        if (mem_sum < mem_lo) begin
            mem_lvl = MEM_LOW;
        end else if (mem_sum >= mem_hi) begin
            mem_lvl = MEM_HIGH;
        end else begin
            mem_lvl = MEM_MID;
        end
    end

    // Map the levels to an adjustment
    always_comb begin
        if (idle_high) begin
            adj = ADJ_UP;
        end else begin
            case (mem_lvl)
                MEM_LOW:  adj = ADJ_UP;
                MEM_HIGH: adj = ADJ_DOWN;
                default:  adj = ADJ_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/tlp_target_regulator.sv
// Keeps the target CTA count, the resident count and the pause count.
// The target moves only at a window end and saturates at 1 and MAX_CTA.
// The pause count steps by one per cycle toward
// max(0, resident - target), and is recomputed from the next-cycle target
// and resident values.
// A completing CTA is assumed to be one of the resident ones.
module tlp_target_regulator
    import tlp_pkg::*;
#(
    parameter int MAX_CTA = 8,
    parameter int CW      = $clog2(MAX_CTA + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_end,
    input  adj_e          adj,
    input  logic          cta_launch,
    input  logic          cta_retire,
    output logic [CW-1:0] target,
    output logic [CW-1:0] active,
    output logic [CW-1:0] paused
);

    localparam logic [CW-1:0] MAX_V  = CW'(MAX_CTA);
    localparam logic [CW-1:0] INIT_V = CW'(MAX_CTA / 2);
    localparam logic [CW-1:0] ONE_V  = CW'(1);

    logic [CW-1:0] target_nx;
    logic [CW-1:0] active_nx;
    logic [CW-1:0] paused_cl;
    logic [CW-1:0] paused_nx;
    logic [CW-1:0] runnable;
    logic          inc_ok;
    logic          dec_ok;

    // Next target: one step per window, saturating
    always_comb begin
        target_nx = target;
        if (win_end) begin
            if (adj == ADJ_UP && target < MAX_V) begin
                target_nx = target + ONE_V;
            end else if (adj == ADJ_DOWN && target > ONE_V) begin
                target_nx = target - ONE_V;
            end
        end
    end

    // Next resident count from launch and retire events
    always_comb begin
        inc_ok    = cta_launch && (active < MAX_V);
        dec_ok    = cta_retire && (active != '0);
        active_nx = active + CW'(inc_ok) - CW'(dec_ok);
    end

    // Next pause count: clamp to resident, then one step toward balance
    always_comb begin
        paused_cl = (paused > active_nx) ? active_nx : paused;
        runnable  = active_nx - paused_cl;
        if (runnable > target_nx) begin
            paused_nx = paused_cl + ONE_V;
        end else if (runnable < target_nx && paused_cl != '0) begin
            paused_nx = paused_cl - ONE_V;
        end else begin
            paused_nx = paused_cl;
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= INIT_V;
            active <= '0;
            paused <= '0;
        end else begin
            target <= target_nx;
            active <= active_nx;
            paused <= paused_nx;
        end
    end

endmodule

// File: rtl/tlp_limit_ctrl.sv
// Top level of the adaptive per-core CTA limit controller.
// Samples the core's stall pulses per window, decides an adjustment,
// regulates the target, and derives the pause and new-CTA requests.
// Assumes MAX_CTA >= 2 and a configured window of at least one cycle.
module tlp_limit_ctrl
    import tlp_pkg::*;
#(
    parameter int MAX_CTA = 8,
    parameter int CNT_W   = 16,
    parameter int CW      = $clog2(MAX_CTA + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_window,
    input  logic [CNT_W-1:0] cfg_idle_thr,
    input  logic [CNT_W-1:0] cfg_mem_lo,
    input  logic [CNT_W-1:0] cfg_mem_hi,
    input  logic             core_idle,
    input  logic             core_mem_wait,
    input  logic             cta_launch,
    input  logic             cta_retire,
    output logic [CW-1:0]    target_cta,
    output logic [CW-1:0]    pause_cnt,
    output logic             pause_req,
    output logic             grant_req
);

    logic [CNT_W-1:0] win_len;
    logic [CNT_W-1:0] idle_thr;
    logic [CNT_W-1:0] mem_lo;
    logic [CNT_W-1:0] mem_hi;
    logic             win_end;
    logic [CNT_W-1:0] idle_sum;
    logic [CNT_W-1:0] mem_sum;
    adj_e             adj;
    logic [CW-1:0]    active_cta;

    tlp_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_window   (cfg_window),
        .in_idle_thr (cfg_idle_thr),
        .in_mem_lo   (cfg_mem_lo),
        .in_mem_hi   (cfg_mem_hi),
        .win_len     (win_len),
        .idle_thr    (idle_thr),
        .mem_lo      (mem_lo),
        .mem_hi      (mem_hi)
    );

    tlp_stall_sampler #(.CNT_W(CNT_W)) u_sampler (
        .clk           (clk),
        .rst_n         (rst_n),
        .win_len       (win_len),
        .core_idle     (core_idle),
        .core_mem_wait (core_mem_wait),
        .win_end       (win_end),
        .idle_sum      (idle_sum),
        .mem_sum       (mem_sum)
    );

    tlp_adjust_decider #(.CNT_W(CNT_W)) u_decider (
        .idle_sum (idle_sum),
        .mem_sum  (mem_sum),
        .idle_thr (idle_thr),
        .mem_lo   (mem_lo),
        .mem_hi   (mem_hi),
        .adj      (adj)
    );

    tlp_target_regulator #(.MAX_CTA(MAX_CTA), .CW(CW)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_end    (win_end),
        .adj        (adj),
        .cta_launch (cta_launch),
        .cta_retire (cta_retire),
        .target     (target_cta),
        .active     (active_cta),
        .paused     (pause_cnt)
    );

    // Requests: pause flag, and a new CTA only when nothing is paused
    always_comb begin
        pause_req = (pause_cnt != '0);
        grant_req = (pause_cnt == '0) && (active_cta < target_cta);
    end

endmodule

// File: rtl/tlp_limit_ctrl_chk.sv
// Assertion checker for tlp_limit_ctrl, attached by bind.
// Observes the outputs together with the window-end strobe, the resident
// count and the latched window length.
module tlp_limit_ctrl_chk #(
    parameter int MAX_CTA = 8,
    parameter int CNT_W   = 16,
    parameter int CW      = $clog2(MAX_CTA + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_end,
    input logic [CNT_W-1:0] win_len,
    input logic [CW-1:0]    target_cta,
    input logic [CW-1:0]    pause_cnt,
    input logic [CW-1:0]    active_cta,
    input logic             pause_req
);

    localparam logic [CW-1:0] MAX_V = CW'(MAX_CTA);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    // R8
    target_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (target_cta >= ONE_V) && (target_cta <= MAX_V));

    // R2
    target_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(target_cta));

    // R3
    target_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (target_cta == $past(target_cta))
                 || (target_cta == $past(target_cta) + ONE_V)
                 || (target_cta == $past(target_cta) - ONE_V));

    // R9
    pause_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_cnt <= active_cta);

    // R9
    pause_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pause_cnt == $past(pause_cnt))
              || (pause_cnt == $past(pause_cnt) + ONE_V)
              || (pause_cnt == $past(pause_cnt) - ONE_V));

    // R10
    pause_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_req) |-> (active_cta > target_cta));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(win_len));

endmodule

bind tlp_limit_ctrl tlp_limit_ctrl_chk #(
    .MAX_CTA (MAX_CTA),
    .CNT_W   (CNT_W),
    .CW      (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_end    (win_end),
    .win_len    (win_len),
    .target_cta (target_cta),
    .pause_cnt  (pause_cnt),
    .active_cta (active_cta),
    .pause_req  (pause_req)
);

// File: tb/tlp_limit_ctrl_test.sv
// Scoreboard bench for tlp_limit_ctrl.
// The driver plays one window at a time and queues the expected state for
// the cycle after that window. The monitor compares on falling edges.
module tlp_limit_ctrl_test;

    localparam int N    = 8;
    localparam int CW   = $clog2(N + 1);
    localparam int W    = 32;
    localparam int ITHR = 4;
    localparam int MLO  = 8;
    localparam int MHI  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cfg_window = 16'(W);
    logic [15:0]   cfg_idle_thr = 16'(ITHR);
    logic [15:0]   cfg_mem_lo = 16'(MLO);
    logic [15:0]   cfg_mem_hi = 16'(MHI);
    logic          core_idle = 1'b0;
    logic          core_mem_wait = 1'b0;
    logic          cta_launch = 1'b0;
    logic          cta_retire = 1'b0;
    logic [CW-1:0] target_cta;
    logic [CW-1:0] pause_cnt;
    logic          pause_req;
    logic          grant_req;

    tlp_limit_ctrl #(.MAX_CTA(N), .CNT_W(16)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_window    (cfg_window),
        .cfg_idle_thr  (cfg_idle_thr),
        .cfg_mem_lo    (cfg_mem_lo),
        .cfg_mem_hi    (cfg_mem_hi),
        .core_idle     (core_idle),
        .core_mem_wait (core_mem_wait),
        .cta_launch    (cta_launch),
        .cta_retire    (cta_retire),
        .target_cta    (target_cta),
        .pause_cnt     (pause_cnt),
        .pause_req     (pause_req),
        .grant_req     (grant_req)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    due;
        int    tgt;
        int    pcnt;
        bit    grant;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   m_tgt = N / 2;
    int   m_act = 0;
    int   m_win = 0;
    bit   done = 1'b0;

    // Count clock edges since reset release
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Model one window from the requirements, queue the result, drive it
    task automatic run_win(int n_idle, int n_mem, int n_launch, int n_retire,
                           string tag);
        exp_t e;
        int   p;
        if (n_idle >= ITHR) m_tgt = m_tgt + 1;      // R3
        else if (n_mem < MLO) m_tgt = m_tgt + 1;    // R4
        else if (n_mem >= MHI) m_tgt = m_tgt - 1;   // R6
        if (m_tgt > N) m_tgt = N;                   // R8
        if (m_tgt < 1) m_tgt = 1;
        m_act = m_act + n_launch - n_retire;
        p = (m_act > m_tgt) ? m_act - m_tgt : 0;
        m_win++;
        e.due   = m_win * W;
        e.tgt   = m_tgt;
        e.pcnt  = p;
        e.grant = (p == 0) && (m_act < m_tgt);
        e.tag   = tag;
        q.push_back(e);
        for (int c = 0; c < W; c++) begin
            core_idle     = (c < n_idle);
            core_mem_wait = (c < n_mem);
            cta_launch    = (c < n_launch);
            cta_retire    = (c < n_retire);
            @(posedge clk);
            @(negedge clk);
        end
        core_idle = 0; core_mem_wait = 0; cta_launch = 0; cta_retire = 0;
    endtask

    // Monitor: compare queued items on their due cycle
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "target", int'(target_cta), e.tgt);
                check(e.tag, "pause_cnt", int'(pause_cnt), e.pcnt);
                check(e.tag, "pause_req", int'(pause_req), int'(e.pcnt != 0));
                check(e.tag, "grant_req", int'(grant_req), int'(e.grant));
            end
        end
    end

    // Driver
    initial begin
        exp_t r;
        r.due = 0; r.tgt = N / 2; r.pcnt = 0; r.grant = 1'b1; r.tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        q.push_back(r);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: new configuration values must not take effect
        cfg_window = 16'd5; cfg_idle_thr = 16'd1;
        cfg_mem_lo = 16'd2; cfg_mem_hi = 16'd3;
        run_win(10, 0, 4, 0, "R3");
        run_win(0, 5, 1, 0, "R4");
        run_win(0, 10, 0, 0, "R5");
        run_win(3, 20, 1, 0, "R6");
        run_win(0, 19, 0, 0, "R7");
        run_win(0, 7, 0, 0, "R9");
        run_win(4, 30, 0, 0, "R3");
        run_win(32, 0, 0, 0, "R8");
        run_win(32, 0, 0, 0, "R8");
        run_win(0, 8, 0, 0, "R5");
        for (int k = 0; k < 7; k++) run_win(0, 32, 0, 0, "R6");
        run_win(0, 32, 0, 0, "R8");
        run_win(0, 32, 0, 3, "R10");
        run_win(W, 0, 0, 0, "R2");
        run_win(W, 0, 0, 0, "R10");
        run_win(W, 0, 0, 0, "R11");
        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
    end

    // Watchdog
    initial begin
        #(100000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule